// File: doc/BRIEF.md
# High-Voltage-Controlled Erasable EPROM Model

A synthesizable behavioural model of a word-wide electrically erasable EPROM. The analog supply and high-voltage pins are reduced to three digital level flags: the programming supply at program level, the programming supply at erase level, and the A9 address line at identifier/erase voltage. The model decodes an operating mode from these flags together with the active-low chip enable and output enable. It then reads, programs, erases, verifies, stays in standby or returns a signature word, as the mode requires. Timing and supply-current behaviour are not modelled. The depth is set by a parameter so that the array stays small.

All decoding and output selection are combinational from the present inputs and the stored array. Array changes happen only on a clock edge. A program or erase takes effect at the end of a chip-enable-low pulse, and only if the pulse completed cleanly. A word is readable in the cycle after the clock edge that first samples chip enable high.

Top module: `hv_eprom_model`

## Requirements
- R1: With both supply flags low, `ce_n`=0, `oe_n`=0 and `a9_hv`=0, `mode` is 2, `dout_en` is 1 and `dout` is the word stored at `addr`.
- R2: With both supply flags low and `ce_n`=1, `mode` is 0 (standby) whatever `oe_n` is. With `ce_n`=0 and `oe_n`=1, `mode` is 1 (output disabled). In both cases `dout_en` is 0 and `dout` is all zeros.
- R3: With `vpp_prog`=1, `vpp_erase`=0, `ce_n`=0 and `oe_n`=1, `mode` is 4 (program). When the pulse ends cleanly, the word at the captured address becomes old AND `din`, so bits only go from 1 to 0. The new value is visible from the cycle after the edge that samples `ce_n` high.
- R4: With either supply flag high, `ce_n`=1 and `oe_n`=0, `mode` is 5 (verify), `dout_en` is 1 and `dout` is the stored word at `addr`.
- R5: With either supply flag high, `ce_n`=1 and `oe_n`=1, `mode` is 6 (inhibit) and `dout_en` is 0. Data and address applied in this mode leave the array unchanged.
- R6: Mode 7 (erase) is decoded only when `vpp_erase`=1, `ce_n`=0, `oe_n`=1, `a9_hv`=1, `addr` is all zeros and `din` is all ones. If any of these conditions is missing while `ce_n`=0 and `oe_n`=1 at erase level, the mode is 8 (illegal). A clean erase pulse sets every word to all ones, visible one cycle after the ending edge.
- R7: With both supply flags low, `ce_n`=0, `oe_n`=0 and `a9_hv`=1, `mode` is 3. `dout` is `MFR_CODE` (16'h00DA) when `addr[0]`=0 and `DEV_CODE` (16'h000D) when `addr[0]`=1.
- R8: A pulse is aborted, and the array is left unchanged, in three cases: the mode, `addr` or `din` changes during the pulse; the pulse ends by anything other than `ce_n` rising; or the pulse ends without the supply still at the pulse's level.
- R9: `vpp_erase` takes priority over `vpp_prog`. Either supply flag high with `ce_n`=0 and `oe_n`=0 gives mode 8 with the outputs floating.
- R10: Reset (`rst_n`=0) sets every word to all ones and discards any pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples pulses and updates the array |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_prog | input | 1 | Supply at programming level |
| vpp_erase | input | 1 | Supply at erase level (wins over vpp_prog) |
| a9_hv | input | 1 | A9 at high voltage |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Data to program / erase pattern |
| dout | output | DATA_W | Output word, zero when not driven |
| dout_en | output | 1 | Output driven (read, verify, signature) |
| mode | output | 4 | Decoded mode code 0..8 |

## Verification
`mode`, `dout_en` and `dout` follow the inputs within the same cycle, so each vector is applied at a falling edge and its result is sampled two nanoseconds later, before the next rising edge. Programming and erasing change the array on the rising edge that first sees `ce_n` high. The bench therefore checks the stored word twice: once in the cycle that ends the pulse, where the old value is still expected, and once in the following cycle, where the new value is expected. Aborted pulses and inhibit stimulus are followed by a verify or read of the affected words.

// File: rtl/hv_eprom_model.sv
module hv_eprom_model #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00DA,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h000D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_prog,
  input  logic              vpp_erase,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [3:0]        mode
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [3:0] M_STANDBY = 4'd0, M_OUTDIS = 4'd1, M_READ = 4'd2,
                         M_SIG = 4'd3, M_PROG = 4'd4, M_VERIFY = 4'd5,
                         M_INHIBIT = 4'd6, M_ERASE = 4'd7, M_ILLEGAL = 4'd8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              pend, pend_erase, pend_ok;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  wire hv        = vpp_prog | vpp_erase;
  wire erase_ok  = a9_hv && (addr == '0) && (&din);
  wire pulse_on  = (mode == M_PROG) || (mode == M_ERASE);
  wire level_ok  = pend_erase ? vpp_erase : (vpp_prog && !vpp_erase);
  wire commit    = pend && !pulse_on && ce_n && pend_ok && level_ok;

  always_comb begin
    if (!hv) begin
      if (ce_n)       mode = M_STANDBY;
      else if (oe_n)  mode = M_OUTDIS;
      else if (a9_hv) mode = M_SIG;
      else            mode = M_READ;
    end else if (ce_n) begin
      mode = oe_n ? M_INHIBIT : M_VERIFY;
    end else if (!oe_n) begin
      mode = M_ILLEGAL;
    end else if (vpp_erase) begin
      mode = erase_ok ? M_ERASE : M_ILLEGAL;
    end else begin
      mode = M_PROG;
    end
  end

  assign dout_en = (mode == M_READ) || (mode == M_VERIFY) || (mode == M_SIG);
  assign dout = !dout_en ? '0 :
                (mode == M_SIG) ? (addr[0] ? DEV_CODE : MFR_CODE) : mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_erase <= 1'b0;
      pend_ok    <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
    end else if (pulse_on) begin
      if (!pend) begin
        pend       <= 1'b1;
        pend_erase <= (mode == M_ERASE);
        pend_ok    <= 1'b1;
        pend_addr  <= addr;
        pend_data  <= din;
      end else if (((mode == M_ERASE) != pend_erase) || (addr != pend_addr) ||
                   (din != pend_data)) begin
        pend_ok <= 1'b0;
      end
    end else begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit) begin
      if (pend_erase) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else begin
        mem[pend_addr] <= mem[pend_addr] & pend_data;
      end
    end
  end
endmodule

// File: rtl/hv_eprom_model_chk.sv
module hv_eprom_model_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00DA,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h000D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_prog,
  input logic              vpp_erase,
  input logic              a9_hv,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic [3:0]        mode
);
  wire nrm = !vpp_prog && !vpp_erase;
  wire hi  = vpp_prog || vpp_erase;
  wire pl  = vpp_prog && !vpp_erase;

  assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm && !ce_n && !oe_n && !a9_hv) |-> (dout_en && mode == 4'd2));

  assert_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm && (ce_n || oe_n)) |-> (!dout_en && dout == '0));

  assert_clear_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd5 && $past(mode) == 4'd5 && pl && $past(pl) && $stable(addr))
      |-> ((dout & ~$past(dout)) == '0));

  assert_verify_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && ce_n && !oe_n) |-> (dout_en && mode == 4'd5));

  assert_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && ce_n && oe_n) |-> (!dout_en && mode == 4'd6));

  assert_erase_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd7) |-> (vpp_erase && a9_hv && addr == '0 && (&din) && !ce_n && oe_n));

  assert_signature_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm && !ce_n && !oe_n && a9_hv) |-> (dout == (addr[0] ? DEV_CODE : MFR_CODE)));

  assert_hv_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && !ce_n && !oe_n) |-> (mode == 4'd8 && !dout_en));
endmodule

bind hv_eprom_model hv_eprom_model_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_prog(vpp_prog),
  .vpp_erase(vpp_erase), .a9_hv(a9_hv), .addr(addr), .din(din),
  .dout(dout), .dout_en(dout_en), .mode(mode)
);

// File: tb/hv_eprom_model_tb_top.sv
module hv_eprom_model_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, vp = 1'b0, ve = 1'b0, a9 = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;
  logic [3:0] mode;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hv_eprom_model #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_prog(vp),
    .vpp_erase(ve), .a9_hv(a9), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .mode(mode)
  );

  // {ce_n,oe_n,vp,ve,a9,addr[4],din[16], en,mode[4],dout[16]}
  localparam logic [45:0] VECS [14] = '{
    {5'b10000, 4'd0, 16'h0000, 1'b0, 4'd0, 16'h0000},  // R2 standby, oe low
    {5'b11000, 4'd0, 16'h0000, 1'b0, 4'd0, 16'h0000},  // R2 standby
    {5'b01000, 4'd3, 16'h0000, 1'b0, 4'd1, 16'h0000},  // R2 output disabled
    {5'b00000, 4'd3, 16'h0000, 1'b1, 4'd2, 16'hFFFF},  // R1 read
    {5'b00001, 4'd0, 16'h0000, 1'b1, 4'd3, 16'h00DA},  // R7 maker code
    {5'b00001, 4'd1, 16'h0000, 1'b1, 4'd3, 16'h000D},  // R7 device code
    {5'b10100, 4'd2, 16'h0000, 1'b1, 4'd5, 16'hFFFF},  // R4 verify prog level
    {5'b10010, 4'd2, 16'h0000, 1'b1, 4'd5, 16'hFFFF},  // R4 verify erase level
    {5'b11100, 4'd0, 16'h0000, 1'b0, 4'd6, 16'h0000},  // R5 inhibit
    {5'b01100, 4'd0, 16'h0000, 1'b0, 4'd4, 16'h0000},  // R3 program decode
    {5'b01011, 4'd0, 16'hFFFF, 1'b0, 4'd7, 16'h0000},  // R6 erase decode
    {5'b01011, 4'd0, 16'hFFFE, 1'b0, 4'd8, 16'h0000},  // R6 erase missing cond
    {5'b00100, 4'd0, 16'h0000, 1'b0, 4'd8, 16'h0000},  // R9 ce+oe low at hv
    {5'b01110, 4'd0, 16'h0000, 1'b0, 4'd8, 16'h0000}   // R9 erase level wins
  };

  function automatic string req_of(int i);
    case (i)
      0, 1, 2:    return "R2";
      3:          return "R1";
      4, 5:       return "R7";
      6, 7:       return "R4";
      8:          return "R5";
      9:          return "R3";
      10, 11:     return "R6";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic c, input logic o, input logic p, input logic e,
                        input logic h, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; vp = p; ve = e; a9 = h; addr = a; din = d;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 check("R2 reset standby", {dout_en, mode, dout}, {1'b0, 4'd0, 16'h0000});
    rst_n = 1'b1;
    set_in(0, 0, 0, 0, 0, 4'd5, 0);
    #2 check("R10 reset array ones", {dout_en, mode, dout}, {1'b1, 4'd2, 16'hFFFF});

    for (int i = 0; i < 14; i++) begin
      set_in(VECS[i][45], VECS[i][44], VECS[i][43], VECS[i][42], VECS[i][41],
             VECS[i][40:37], VECS[i][36:21]);
      #2 check(req_of(i), {dout_en, mode, dout}, VECS[i][20:0]);
    end
    set_in(0, 0, 0, 0, 0, 4'd0, 0);
    #2 check("R8 table pulses aborted", {dout_en, mode, dout}, {1'b1, 4'd2, 16'hFFFF});

    // R3 program with commit latency
    set_in(1, 1, 1, 0, 0, 4'd5, 16'hA5F0);
    set_in(0, 1, 1, 0, 0, 4'd5, 16'hA5F0);
    set_in(0, 1, 1, 0, 0, 4'd5, 16'hA5F0);
    set_in(1, 0, 1, 0, 0, 4'd5, 16'hA5F0);
    #2 check("R3 old value in ending cycle", {dout_en, mode, dout}, {1'b1, 4'd5, 16'hFFFF});
    set_in(1, 0, 1, 0, 0, 4'd5, 16'hA5F0);
    #2 check("R3 programmed value", {dout_en, mode, dout}, {1'b1, 4'd5, 16'hA5F0});
    set_in(1, 1, 1, 0, 0, 4'd5, 16'h0FFF);
    set_in(0, 1, 1, 0, 0, 4'd5, 16'h0FFF);
    set_in(1, 0, 1, 0, 0, 4'd5, 16'h0FFF);
    set_in(0, 0, 0, 0, 0, 4'd5, 0);
    #2 check("R3 bits only cleared", {dout_en, mode, dout}, {1'b1, 4'd2, 16'h05F0});

    // R8 address change mid-pulse
    set_in(1, 1, 1, 0, 0, 4'd6, 0);
    set_in(0, 1, 1, 0, 0, 4'd6, 0);
    set_in(0, 1, 1, 0, 0, 4'd7, 0);
    set_in(1, 0, 1, 0, 0, 4'd6, 0);
    set_in(1, 0, 1, 0, 0, 4'd6, 0);
    #2 check("R8 addr change word6", {dout_en, mode, dout}, {1'b1, 4'd5, 16'hFFFF});
    set_in(1, 0, 1, 0, 0, 4'd7, 0);
    #2 check("R8 addr change word7", {dout_en, mode, dout}, {1'b1, 4'd5, 16'hFFFF});

    // R8 supply drop ends pulse
    set_in(1, 1, 1, 0, 0, 4'd6, 0);
    set_in(0, 1, 1, 0, 0, 4'd6, 0);
    set_in(0, 1, 0, 0, 0, 4'd6, 0);
    set_in(1, 0, 1, 0, 0, 4'd6, 0);
    set_in(1, 0, 1, 0, 0, 4'd6, 0);
    #2 check("R8 supply drop", {dout_en, mode, dout}, {1'b1, 4'd5, 16'hFFFF});

    // R5 inhibit leaves array
    set_in(1, 1, 1, 0, 0, 4'd5, 0);
    set_in(1, 1, 1, 0, 0, 4'd5, 0);
    set_in(1, 1, 0, 1, 1, 4'd0, 16'hFFFF);
    set_in(1, 0, 1, 0, 0, 4'd5, 0);
    #2 check("R5 inhibit no change", {dout_en, mode, dout}, {1'b1, 4'd5, 16'h05F0});

    // R8 erase aborted by data change
    set_in(1, 1, 0, 1, 1, 4'd0, 16'hFFFF);
    set_in(0, 1, 0, 1, 1, 4'd0, 16'hFFFF);
    set_in(0, 1, 0, 1, 1, 4'd0, 16'hFFFE);
    set_in(1, 0, 0, 1, 0, 4'd5, 16'hFFFF);
    set_in(1, 0, 0, 1, 0, 4'd5, 16'hFFFF);
    #2 check("R8 erase aborted", {dout_en, mode, dout}, {1'b1, 4'd5, 16'h05F0});

    // R6 clean erase
    set_in(1, 1, 0, 1, 1, 4'd0, 16'hFFFF);
    set_in(0, 1, 0, 1, 1, 4'd0, 16'hFFFF);
    set_in(0, 1, 0, 1, 1, 4'd0, 16'hFFFF);
    set_in(1, 0, 0, 1, 0, 4'd5, 16'hFFFF);
    #2 check("R6 erase ending cycle old", {dout_en, mode, dout}, {1'b1, 4'd5, 16'h05F0});
    set_in(1, 0, 0, 1, 0, 4'd5, 16'hFFFF);
    #2 check("R6 erased to ones", {dout_en, mode, dout}, {1'b1, 4'd5, 16'hFFFF});

    // R10 reset restores ones
    set_in(1, 1, 1, 0, 0, 4'd3, 16'h1234);
    set_in(0, 1, 1, 0, 0, 4'd3, 16'h1234);
    set_in(1, 0, 1, 0, 0, 4'd3, 16'h1234);
    set_in(1, 0, 1, 0, 0, 4'd3, 16'h1234);
    #2 check("R3 program word3", {dout_en, mode, dout}, {1'b1, 4'd5, 16'h1234});
    set_in(1, 1, 0, 0, 0, 4'd3, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    set_in(0, 0, 0, 0, 0, 4'd3, 0);
    #2 check("R10 reset clears word3", {dout_en, mode, dout}, {1'b1, 4'd2, 16'hFFFF});

    finish_up();
  end
endmodule